// File: doc/BRIEF.md
# Output-Disable Request Input Detector

This block watches a set of active-low emergency pins (two by default). For each pin it raises a sticky request flag once the pin meets the condition picked for it. That condition is either a falling edge, or a run of sixteen consecutive low samples taken on one of three slow strobes. A combined output-disable line is high while any flag is set. Downstream logic uses that line to force the power outputs into a safe state.

Software reaches two registers through a small read/write port. The mode register can be written only once after reset. The flag register is cleared by a handshake: software reads a flag as 1, then writes 0 to it.

Each pin has its own watcher. It is a three-state machine, and the synchronized pin level drives its transitions:

- `ST_HIGH` goes to `ST_HELD` on a low sample in edge mode. This transition reports a request.
- `ST_HIGH` goes to `ST_COUNT` on the first low sample in a filter mode.
- `ST_COUNT` stays in `ST_COUNT` and counts up while the samples stay low.
- `ST_COUNT` goes to `ST_HELD` on the sixteenth low sample. This transition reports a request.
- Any state goes back to `ST_HIGH` on a high sample.
- `ST_HELD` stays in `ST_HELD` while the pin stays low.
- Every state goes to `ST_HIGH` when the mode register write is accepted.

Top module: `odr_detector`

## Requirements
- R1: The mode register is at address 0. Pin 1's mode is in bits 3:2 and pin 0's mode is in bits 1:0. Both modes reset to 00. Bits 5:4 always read 0, whatever was written to them.
- R2: Only the first write to the mode register after reset takes effect. Every later write leaves the mode register unchanged.
- R3: In mode 00, a falling edge of the pin sets the pin's flag within 3 clock cycles. The pin passes through a two-flop synchronizer whose stages reset high, and a low pulse of one clock cycle is enough.
- R4: In mode 01, a pin is sampled on a strobe at clock/8. The flag sets on the sixteenth consecutive low sample. A low of 14×8 cycles leaves the flag clear, and a low of 17×8+4 cycles sets it.
- R5: Modes 10 and 11 work like mode 01 but sample at clock/16 and clock/128. The same 14×div and 17×div+4 bounds apply.
- R6: In a filter mode, a high sample resets the run of low samples to zero. Two low stretches split by a high stretch do not add up.
- R7: Writing 1 to a flag bit never sets or clears it. A write to the flag register does not set a clear flag.
- R8: The flag register is at address 1, with pin 0's flag in bit 0 and pin 1's flag in bit 1. A flag clears when 0 is written to it after a read of the flag register returned it as 1. The read qualifier is dropped once a clear is accepted, so a second write of 0 needs a new read. A write of 0 without such a read does nothing.
- R9: When a new request and an accepted clear hit the same flag in the same cycle, the flag stays 1.
- R10: `out_disable` is high exactly while at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_PINS | Active-low emergency pins, asynchronous |
| reg_addr | input | 1 | Register select: 0 selects the mode register, 1 selects the flag register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe. It arms the clear qualifier of each flag read as 1 |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register, available in the same cycle |
| req_flag | output | NUM_PINS | Sticky request flags, one per pin |
| out_disable | output | 1 | High while any flag is set |

## Verification
The bench sends single-cycle glitches and lows of just under and just over sixteen samples through each filter rate. A watcher that counted on every clock instead of on its strobe, or that took the wrong division, would set the flag too early or too late. A watcher that failed to reset its count on a high sample would add up split lows and set the flag falsely. The bench issues a second mode write, writes 0 to a flag without reading it first, and writes 0 twice after one read. A register block that lost its lock or kept its qualifier armed would then change the mode or clear the flag. The bench also times a clear so that it lands in the same cycle as a new edge. A design that let the clear win would drop a real request.

// File: rtl/odr_pkg.sv
package odr_pkg;

    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_DIV_A = 2'b01,
        MODE_DIV_B = 2'b10,
        MODE_DIV_C = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        ST_HIGH  = 2'b00,
        ST_COUNT = 2'b01,
        ST_HELD  = 2'b10
    } watch_state_e;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;

endpackage

// File: rtl/odr_tick_gen.sv
// Free-running prescaler. Each output is a one-cycle strobe at its
// division, which must be a power of two of at least 2.
module odr_tick_gen #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick
);
    localparam int CW = $clog2(DIV_C);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < 3; k++) begin : g_tick
        localparam int D  = (k == 0) ? DIV_A : (k == 1) ? DIV_B : DIV_C;
        localparam int LW = $clog2(D);
        assign tick[k] = (cnt_q[LW-1:0] == {LW{1'b1}});

        // R4
        tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |=> !tick[k]);
    end

endmodule

// File: rtl/odr_sync.sv
module odr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/odr_pin_watch.sv
module odr_pin_watch
    import odr_pkg::*;
#(
    parameter int FILTER_LEN = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  det_mode_e mode,
    input  logic [2:0] tick,
    input  logic      restart,
    output logic      hit
);
    localparam int CNT_W = $clog2(FILTER_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_LEN - 1);

    watch_state_e     state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             sample_en;

    always_comb begin
        unique case (mode)
            MODE_EDGE:  sample_en = 1'b1;
            MODE_DIV_A: sample_en = tick[0];
            MODE_DIV_B: sample_en = tick[1];
            MODE_DIV_C: sample_en = tick[2];
            default:    sample_en = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        hit     = 1'b0;
        if (restart) begin
            state_n = ST_HIGH;
            cnt_n   = '0;
        end else if (sample_en) begin
            if (pin_s) begin
                state_n = ST_HIGH;
                cnt_n   = '0;
            end else begin
                unique case (state_q)
                    ST_HIGH: begin
                        if (mode == MODE_EDGE) begin
                            hit     = 1'b1;
                            state_n = ST_HELD;
                        end else begin
                            cnt_n   = CNT_W'(1);
                            state_n = ST_COUNT;
                        end
                    end
                    ST_COUNT: begin
                        if (cnt_q >= LAST) begin
                            hit     = 1'b1;
                            cnt_n   = '0;
                            state_n = ST_HELD;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                    ST_HELD: begin
                        state_n = ST_HELD;
                    end
                    default: begin
                        state_n = ST_HIGH;
                        cnt_n   = '0;
                    end
                endcase
            end
        end
    end

    // R6
    high_resets_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && pin_s) |=> (cnt_q == '0));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(FILTER_LEN));

    // R3
    hit_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !pin_s);

endmodule

// File: rtl/odr_regs.sv
module odr_regs
    import odr_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int REG_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_PINS-1:0]   set_i,
    output logic [2*NUM_PINS-1:0] mode_o,
    output logic                  mode_wr_o,
    output logic [NUM_PINS-1:0]   flag_o
);
    localparam int MW = 2 * NUM_PINS;

    logic [MW-1:0]       mode_q;
    logic                locked_q;
    logic [NUM_PINS-1:0] flag_q, armed_q, clr;
    logic                flag_wr, flag_rd;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:MW];

    assign mode_wr_o = reg_wr && (reg_addr == ADDR_MODE) && !locked_q;
    assign flag_wr   = reg_wr && (reg_addr == ADDR_FLAG);
    assign flag_rd   = reg_rd && (reg_addr == ADDR_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            locked_q <= 1'b0;
        end else if (mode_wr_o) begin
            mode_q   <= reg_wdata[MW-1:0];
            locked_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
        assign clr[i] = flag_wr && !reg_wdata[i] && armed_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i]  <= 1'b0;
                armed_q[i] <= 1'b0;
            end else begin
                if (set_i[i])    flag_q[i] <= 1'b1;
                else if (clr[i]) flag_q[i] <= 1'b0;

                if (clr[i])                      armed_q[i] <= 1'b0;
                else if (flag_rd && flag_q[i])   armed_q[i] <= 1'b1;
            end
        end

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);

        // R7
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[i] && !set_i[i]) |=> !flag_q[i]);

        // R8
        clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !flag_wr) |=> flag_q[i]);
    end

    assign mode_o    = mode_q;
    assign flag_o    = flag_q;
    assign reg_rdata = (reg_addr == ADDR_MODE) ? REG_W'(mode_q) : REG_W'(flag_q);

    // R2
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

endmodule

// File: rtl/odr_detector.sv
module odr_detector
    import odr_pkg::*;
#(
    parameter int NUM_PINS   = 2,
    parameter int REG_W      = 6,
    parameter int DIV_A      = 8,
    parameter int DIV_B      = 16,
    parameter int DIV_C      = 128,
    parameter int FILTER_LEN = 16,
    parameter int SYNC_LEN   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n,
    input  logic                reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [NUM_PINS-1:0] req_flag,
    output logic                out_disable
);
    logic [2:0]            tick;
    logic [2*NUM_PINS-1:0] mode_bus;
    logic                  mode_wr;
    logic [NUM_PINS-1:0]   pin_s, hit;

    odr_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        odr_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_n[i]),
            .q    (pin_s[i])
        );

        odr_pin_watch #(.FILTER_LEN(FILTER_LEN)) u_watch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_s  (pin_s[i]),
            .mode   (det_mode_e'(mode_bus[2*i +: 2])),
            .tick   (tick),
            .restart(mode_wr),
            .hit    (hit[i])
        );
    end

    odr_regs #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .set_i    (hit),
        .mode_o   (mode_bus),
        .mode_wr_o(mode_wr),
        .flag_o   (req_flag)
    );

    assign out_disable = |req_flag;

    // R10
    disable_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> out_disable);

endmodule

// File: tb/tb_odr_detector.sv
module tb_odr_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_n = 2'b11;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic [1:0] req_flag;
    logic       out_disable;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    odr_detector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (pin_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .req_flag   (req_flag),
        .out_disable(out_disable)
    );

    // {pin, mode, low cycles, expected flag}
    localparam logic [19:0] VECS [8] = '{
        {1'b0, 2'd0, 16'd4,    1'b1},
        {1'b1, 2'd0, 16'd1,    1'b1},
        {1'b0, 2'd1, 16'd112,  1'b0},
        {1'b1, 2'd1, 16'd140,  1'b1},
        {1'b0, 2'd2, 16'd224,  1'b0},
        {1'b1, 2'd2, 16'd276,  1'b1},
        {1'b1, 2'd3, 16'd1792, 1'b0},
        {1'b0, 2'd3, 16'd2180, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_n = 2'b11; reg_wr = 1'b0; reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [5:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [5:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold_low(input int p, input int cycles);
        @(negedge clk);
        pin_n[p] = 1'b0;
        repeat (cycles) @(negedge clk);
        pin_n[p] = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [5:0] rd;
        string      tag;

        // Reset state: R1 R10
        do_reset();
        reg_read(1'b0, rd);
        chk("R1 reset mode", 8'(rd), 8'h00);
        reg_read(1'b1, rd);
        chk("R8 reset flag reg", 8'(rd), 8'h00);
        chk("R10 reset disable", 8'(out_disable), 8'h0);

        // Reserved bits and write-once lock
        reg_write(1'b0, 6'h3F);
        reg_read(1'b0, rd);
        chk("R1 reserved bits read zero", 8'(rd), 8'h0F);
        reg_write(1'b0, 6'h00);
        reg_read(1'b0, rd);
        chk("R2 second write ignored", 8'(rd), 8'h0F);

        // Table of mode/length vectors
        for (int v = 0; v < 8; v++) begin
            logic       p;
            logic [1:0] m;
            logic       e;
            int         len;
            p   = VECS[v][19];
            m   = VECS[v][18:17];
            len = int'(VECS[v][16:1]);
            e   = VECS[v][0];
            tag = (m == 2'd0) ? "R3" : (m == 2'd1) ? "R4" : "R5";
            do_reset();
            reg_write(1'b0, 6'(m) << (2 * p));
            hold_low(int'(p), len);
            chk($sformatf("%s vector %0d flags", tag, v), 8'(req_flag),
                8'(e) << p);
            chk($sformatf("R10 vector %0d disable", v), 8'(out_disable), 8'(e));
        end

        // Flag handshake: R7 R8 R9
        do_reset();
        reg_write(1'b0, 6'h00);
        reg_write(1'b1, 6'h3F);
        chk("R7 write ones does not set", 8'(req_flag), 8'h0);
        hold_low(0, 1);
        chk("R3 single-cycle pulse", 8'(req_flag), 8'h1);
        reg_write(1'b1, 6'h00);
        chk("R8 write 0 without read", 8'(req_flag), 8'h1);
        reg_read(1'b1, rd);
        chk("R8 flag reg readback", 8'(rd), 8'h01);
        reg_write(1'b1, 6'h01);
        chk("R7 write 1 does not clear", 8'(req_flag), 8'h1);
        reg_write(1'b1, 6'h00);
        chk("R8 read then write 0 clears", 8'(req_flag), 8'h0);
        chk("R10 disable drops", 8'(out_disable), 8'h0);

        // Set coinciding with clear
        hold_low(0, 1);
        reg_read(1'b1, rd);
        @(negedge clk);
        pin_n[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 1'b1; reg_wdata = 6'h00; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9 set beats clear", 8'(req_flag), 8'h1);
        pin_n[0] = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(1'b1, 6'h00);
        chk("R8 qualifier dropped after clear", 8'(req_flag), 8'h1);
        reg_read(1'b1, rd);
        reg_write(1'b1, 6'h00);
        chk("R8 re-armed clear", 8'(req_flag), 8'h0);

        // Split lows do not add up
        do_reset();
        reg_write(1'b0, 6'h04);
        @(negedge clk);
        pin_n[1] = 1'b0;
        repeat (96) @(negedge clk);
        pin_n[1] = 1'b1;
        repeat (24) @(negedge clk);
        hold_low(1, 112);
        chk("R6 high sample resets run", 8'(req_flag), 8'h0);
        hold_low(1, 140);
        chk("R6 full run after reset", 8'(req_flag), 8'h2);
        chk("R10 disable from pin 1 only", 8'(out_disable), 8'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule